// File: doc/BRIEF.md
# Master Clock Ratio Detector and 256fs Enable Generator

This block sits at the clock entry of an audio converter and runs entirely on the incoming master clock. The master clock may arrive at 256, 384 or 512 times the sample rate. The block works out which of these it is by counting master clock cycles between rising edges of the sample-rate word clock. That word clock is first brought into the master clock domain through a synchronizer. Downstream logic can then run from one uniform enable that fires 256 times per sample period, whatever the master clock ratio.

The enable is a pass-through at 256fs. At 512fs it is asserted on alternate cycles, and at 384fs on two of every three cycles (a 2/3 divide). Its phase restarts on every synchronized word-clock rising edge, so internal timing starts from a word-clock edge. A ratio is only accepted after two successive word-clock periods fall in the same tolerance window. If the word clock stops, or its period matches no legal ratio, the block drops its clocks-valid flag and forces the power-down request. No configuration pin is involved, and the phase between the two clocks does not matter.

Top module: `mclk_ratio_div`

## Requirements
- R1: While `rst` is high at a rising clock edge, and in the cycle after it, `clk_valid` is 0, `pdn_force` is 1, `ratio_code` is 0 and `ce_256` is 0.
- R2: A measured word-clock period of N master cycles is classified as 256fs (`ratio_code` = 1) when |N-256| <= 2, as 384fs (code 2) when |N-384| <= 2, and as 512fs (code 3) when |N-512| <= 2. Code 0 means no ratio.
- R3: The first synchronized rising edge after reset only starts a measurement. Lock (`clk_valid` = 1) needs two consecutive measured periods in the same class, so it comes on the third rising edge at the earliest.
- R4: A measured period outside every window of R2 clears the lock at once.
- R5: When locked, a measured period in a different legal class clears the lock. One further period of that new class then locks to it.
- R6: If no word-clock rising edge arrives for 1024 master cycles, the lock is cleared. It stays locked when an edge arrives within about 1000 cycles.
- R7: When locked at 256fs, `ce_256` is 1 on every cycle.
- R8: When locked at 512fs, `ce_256` alternates 1,0,1,0, starting with 1 in the first cycle after each edge is detected.
- R9: When locked at 384fs, `ce_256` follows 1,1,0 repeating from each detected edge, so two zero cycles are never adjacent.
- R10: Over a word-clock period of exactly 256, 384 or 512 master cycles while locked, `ce_256` is asserted exactly 256 times.
- R11: Whenever `clk_valid` is 0, `pdn_force` is 1, `ratio_code` is 0 and `ce_256` is 0.
- R12: Detection does not depend on the word clock's duty cycle, on its phase against the master clock, or on period jitter within the windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every register in the block uses it |
| rst | input | 1 | Synchronous active-high reset |
| lrck_in | input | 1 | Sample-rate word clock, asynchronous to the register timing |
| ce_256 | output | 1 | Uniform 256fs clock enable for downstream logic |
| ratio_code | output | 2 | Detected ratio: 0 none, 1 256fs, 2 384fs, 3 512fs |
| clk_valid | output | 1 | Clocks present and a ratio is locked |
| pdn_force | output | 1 | Holds the design in power-down while clocks are invalid |

## Verification
Some properties hold on every cycle, and the in-line assertions check these. The enable stays silent while unlocked. The 512fs enable never repeats a 1 between edges, and the 384fs enable never runs three 1s without an edge. The idle counter saturates and raises the timeout, and the timeout always removes the lock. A lock only appears right after a measurement. The bench scenarios cover what needs whole periods: which class a given period length falls into, at the edges of the ±2 windows; that lock comes only on the third edge; relocking after a change of ratio; the 1024-cycle timeout against a 1000-cycle gap; and the exact count of 256 enables per period under random duty, offset and jitter.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;

    typedef enum logic [1:0] {
        RATIO_NONE = 2'd0,
        RATIO_256  = 2'd1,
        RATIO_384  = 2'd2,
        RATIO_512  = 2'd3
    } ratio_e;

    typedef struct packed {
        logic   locked;
        ratio_e held;
        ratio_e cand;
    } lock_state_t;

    localparam lock_state_t LOCK_CLEAR = '{locked: 1'b0, held: RATIO_NONE, cand: RATIO_NONE};

    // Window classification: nominal = base * k / 2 for k = 2, 3, 4.
    function automatic ratio_e classify(input int unsigned meas,
                                        input int unsigned base,
                                        input int unsigned tol);
        ratio_e      r;
        int unsigned nom;
        r = RATIO_NONE;
        for (int k = 2; k <= 4; k++) begin
            nom = (base * k) / 2;
            if ((meas + tol >= nom) && (meas <= nom + tol))
                r = ratio_e'(k - 1);
        end
        return r;
    endfunction

    // Length of the repeating enable pattern for each ratio.
    function automatic logic [1:0] pattern_span(input ratio_e r);
        case (r)
            RATIO_384: return 2'd3;
            RATIO_512: return 2'd2;
            default:   return 2'd1;
        endcase
    endfunction

    // Enable bit for a given phase in the pattern.
    function automatic logic pattern_bit(input ratio_e r, input logic [1:0] ph);
        case (r)
            RATIO_256: return 1'b1;
            RATIO_384: return (ph != 2'd2);
            RATIO_512: return (ph == 2'd0);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mrd_lrck_edge.sv
module mrd_lrck_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lrck_in,
    output logic rise
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SH_W-2:0], lrck_in};
    end

    assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

endmodule

// File: rtl/mrd_period_meter.sv
module mrd_period_meter #(
    parameter int TIMEOUT = 1024,
    parameter int CNT_W   = $clog2(TIMEOUT + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas,
    output logic             timeout
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    logic [CNT_W-1:0] elapsed;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
            armed   <= 1'b0;
        end else if (rise) begin
            elapsed <= '0;
            armed   <= 1'b1;
        end else if (elapsed != LIMIT) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign meas_valid = rise & armed;
    assign meas       = elapsed + 1'b1;
    assign timeout    = (elapsed == LIMIT);

    // R6: idle counter never passes its limit
    a_r6_count_saturates: assert property (@(posedge clk) disable iff (rst)
        elapsed <= LIMIT);

    // R6: timeout persists until an edge arrives
    a_r6_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
        (timeout && !rise) |=> timeout);

endmodule

// File: rtl/mrd_ratio_judge.sv
module mrd_ratio_judge
    import mclk_ratio_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int BASE_RATIO = 256,
    parameter int TOL        = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas,
    input  logic             timeout,
    output logic             locked,
    output ratio_e           ratio
);
    lock_state_t st;
    ratio_e      cls;

    always_comb cls = classify(32'(meas), BASE_RATIO, TOL);

    always_ff @(posedge clk) begin
        if (rst || timeout) begin
            st <= LOCK_CLEAR;
        end else if (meas_valid) begin
            if (cls == RATIO_NONE) begin
                st <= LOCK_CLEAR;
            end else if (cls == st.cand) begin
                st.locked <= 1'b1;
                st.held   <= cls;
            end else begin
                st.locked <= 1'b0;
                st.held   <= RATIO_NONE;
                st.cand   <= cls;
            end
        end
    end

    assign locked = st.locked;
    assign ratio  = st.held;

    // R3: lock only ever appears right after a measurement
    a_r3_lock_after_meas: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(meas_valid));

    // R2: a locked state always carries a legal ratio
    a_r2_lock_has_ratio: assert property (@(posedge clk) disable iff (rst)
        locked |-> (ratio != RATIO_NONE));

endmodule

// File: rtl/mrd_ce_gen.sv
module mrd_ce_gen
    import mclk_ratio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   locked,
    input  ratio_e ratio,
    input  logic   rise,
    output logic   ce
);
    logic [1:0] ph;
    logic [1:0] span;

    always_comb span = pattern_span(ratio);

    always_ff @(posedge clk) begin
        if (rst || rise)            ph <= 2'd0;
        else if (ph >= span - 2'd1) ph <= 2'd0;
        else                        ph <= ph + 2'd1;
    end

    assign ce = locked & pattern_bit(ratio, ph);

    // R8: at 512fs an asserted enable is followed by a gap unless an edge restarts
    a_r8_half_gap: assert property (@(posedge clk) disable iff (rst)
        (locked && ratio == RATIO_512 && ce && !rise) |=> !ce);

    // R9: at 384fs two enables in a row are followed by a gap
    a_r9_two_of_three: assert property (@(posedge clk) disable iff (rst)
        (locked && ratio == RATIO_384 && ce && $past(ce) && !rise && !$past(rise)) |=> !ce);

endmodule

// File: rtl/mclk_ratio_div.sv
module mclk_ratio_div
    import mclk_ratio_pkg::*;
#(
    parameter int BASE_RATIO  = 256,
    parameter int TOL         = 2,
    parameter int TIMEOUT     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lrck_in,
    output logic       ce_256,
    output logic [1:0] ratio_code,
    output logic       clk_valid,
    output logic       pdn_force
);
    localparam int CNT_W = $clog2(TIMEOUT + 2);

    logic             rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas;
    logic             timeout;
    logic             locked;
    ratio_e           ratio;

    mrd_lrck_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .lrck_in(lrck_in), .rise(rise)
    );

    mrd_period_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst(rst), .rise(rise),
        .meas_valid(meas_valid), .meas(meas), .timeout(timeout)
    );

    mrd_ratio_judge #(.CNT_W(CNT_W), .BASE_RATIO(BASE_RATIO), .TOL(TOL)) u_judge (
        .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas(meas),
        .timeout(timeout), .locked(locked), .ratio(ratio)
    );

    mrd_ce_gen u_ce (
        .clk(clk), .rst(rst), .locked(locked), .ratio(ratio),
        .rise(rise), .ce(ce_256)
    );

    assign clk_valid  = locked;
    assign pdn_force  = ~locked;
    assign ratio_code = ratio;

    // R11: nothing reaches downstream while clocks are invalid
    a_r11_quiet_when_invalid: assert property (@(posedge clk) disable iff (rst)
        !clk_valid |-> (!ce_256 && ratio_code == 2'd0));

    // R6: a missing word clock always removes the lock
    a_r6_timeout_drops: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !clk_valid);

endmodule

// File: tb/tb_mclk_ratio_div.sv
module tb_mclk_ratio_div;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lrck_in = 1'b0;
    logic       ce_256;
    logic [1:0] ratio_code;
    logic       clk_valid;
    logic       pdn_force;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mclk_ratio_div dut (
        .clk(clk), .rst(rst), .lrck_in(lrck_in), .ce_256(ce_256),
        .ratio_code(ratio_code), .clk_valid(clk_valid), .pdn_force(pdn_force)
    );

    always @(posedge clk) cycles <= cycles + 1;

    function automatic int exp_code(input int p);
        if (p >= 254 && p <= 258) return 1;
        if (p >= 382 && p <= 386) return 2;
        if (p >= 510 && p <= 514) return 3;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        lrck_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one word-clock period of p cycles, high for hi; counts enables and pattern faults
    task automatic run_period(input int p, input int hi,
                              output int ones, output int zz, output int oo);
        logic prev;
        ones = 0; zz = 0; oo = 0; prev = 1'bx;
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            if (ce_256) ones++;
            if (i > 0 && !ce_256 && !prev) zz++;
            if (i > 0 && ce_256 && prev) oo++;
            prev = ce_256;
            lrck_in = (i < hi);
        end
    endtask

    task automatic periods(input int p, input int n);
        int o, z, q;
        for (int k = 0; k < n; k++) run_period(p, 1 + ($urandom % (p - 2)), o, z, q);
    endtask

    task automatic check_state(input string req, input int code);
        check(clk_valid == (code != 0), req, clk_valid, code != 0);
        check(int'(ratio_code) == code, req, ratio_code, code);
        check(pdn_force == (code == 0), req, pdn_force, code == 0);
    endtask

    initial begin : watchdog
        wait (cycles >= 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int o, z, q, p, nom, code;
        void'($urandom(32'd5150));

        // R1 reset state
        do_reset();
        @(negedge clk);
        check_state("R1", 0);
        check(ce_256 == 1'b0, "R1 ce", ce_256, 0);

        // R3, R7-R10 per ratio with random start offset
        for (int r = 1; r <= 3; r++) begin
            nom = 128 * (r + 1);
            do_reset();
            repeat ($urandom % 50) @(negedge clk);
            periods(nom, 2);
            check(clk_valid == 1'b0, "R3 two edges", clk_valid, 0);
            periods(nom, 1);
            check_state("R3/R2 third edge", r);
            run_period(nom, nom / 2, o, z, q);
            check(o == 256, "R10 enables per period", o, 256);
            if (r == 1) check(o == nom, "R7 every cycle", o, nom);
            if (r == 3) check(z == 0 && q == 0, "R8 alternation", z + q, 0);
            if (r == 2) check(z == 0 && o == 256, "R9 two of three", z, 0);
        end

        // R2 window boundaries, R12 jitter and duty
        do_reset();
        for (int k = 0; k < 6; k++) periods(382 + ($urandom % 5), 1);
        check_state("R2/R12 jitter 384", 2);
        do_reset();
        periods(258, 3);
        check_state("R2 upper edge 256", 1);
        do_reset();
        periods(510, 3);
        check_state("R2 lower edge 512", 3);

        // R4 out-of-window period drops lock
        do_reset();
        periods(256, 3);
        check_state("R4 pre-lock", 1);
        periods(259, 1);
        periods(256, 1);
        check_state("R4 259 rejected", 0);
        check(ce_256 == 1'b0, "R11 ce off", ce_256, 0);

        // R5 class change
        do_reset();
        periods(256, 3);
        periods(512, 2);
        check_state("R5 change unlocks", 0);
        periods(512, 1);
        check_state("R5 relock 512", 3);

        // R6 timeout, word clock stuck at random level
        do_reset();
        periods(384, 3);
        run_period(384, 192, o, z, q);
        lrck_in = $urandom % 2;
        repeat (1000 - 384) @(negedge clk);
        check_state("R6 alive at 1000", 2);
        repeat (100) @(negedge clk);
        check_state("R6 timed out", 0);

        // R12/R2 random sequence of classes
        for (int it = 0; it < 20; it++) begin
            code = $urandom % 4;
            if (code == 0) begin
                do begin p = 100 + ($urandom % 900); end while (exp_code(p) != 0);
                periods(p, 4);
            end else begin
                for (int k = 0; k < 4; k++) periods(128 * (code + 1) - 2 + ($urandom % 5), 1);
            end
            check_state("R12 random", code);
        end

        // R1 reset while locked
        periods(256, 3);
        do_reset();
        check_state("R1 mid reset", 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule